// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between a synchronous internal bus and an external asynchronous static RAM of 65,536 words by 16 bits. It takes one request at a time from the host (an address, write data, a two-bit byte mask and a read/write flag) and plays out the matching sequence on the memory's active-low chip, write, output and byte-lane enables. The host handshake is a request/ready pair. Read results come back with a one-cycle valid strobe.

The memory's data pins are shared and bidirectional. The controller therefore keeps its outbound data bus and the tristate enable for that bus separate, and it only drives the pins while the memory's output stage is switched off. Each analogue timing limit of the memory is a parameter in nanoseconds. The controller turns each one into a wait count with ceil(time / clock period), and never uses fewer than one cycle. When the direction of transfer changes between two requests, the controller inserts a turnaround interval so that the bus can release.

Top module: `asram_bus_ctrl`

## Requirements
- R1: After reset, host_rdy is 1 and host_rvalid is 0. mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n and mem_ub_n are all 1, and mem_dout_en is 0.
- R2: A request is accepted on a clock edge where host_req and host_rdy are both 1. host_rdy is 0 from the next cycle until the transfer finishes, and mem_ce_n is 1 in every cycle where host_rdy is 1.
- R3: A write holds mem_ce_n low for one address-setup cycle with mem_we_n high, then holds mem_we_n low for WP cycles. WP is the ceiling of max(pulse width, data setup) divided by the clock period, and is at least 1. mem_dout_en is 1 while mem_we_n is low and for one cycle after it rises. mem_addr and mem_dout do not change across the rising edge of mem_we_n.
- R4: mem_dout_en is never 1 while mem_oe_n is 0, and mem_we_n and mem_oe_n are never both 0.
- R5: A read holds mem_ce_n and mem_oe_n low with mem_we_n high for 1+RD cycles. RD is the ceiling of max(access time, cycle time) divided by the clock period, and is at least 1. host_rvalid is 1 for exactly one cycle, 2+RD cycles after acceptance when no turnaround is needed, and carries the word read.
- R6: host_bmask bit 0 selects the low byte (data bits 7:0, pin mem_lb_n) and bit 1 selects the high byte (bits 15:8, pin mem_ub_n). A lane pin is low only while mem_ce_n is low and its mask bit is 1, so a one-lane write leaves the other byte of the word unchanged.
- R7: A lane that is not selected in a read returns zero in host_rdata.
- R8: A request whose direction differs from the previous transfer's direction keeps mem_ce_n high for HZ cycles after acceptance before the memory is enabled. HZ is the ceiling of the output-release time divided by the clock period, and is at least 1. A request in the same direction as the previous transfer, or the first request after reset, enables the memory in the first cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Request present |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Word address |
| host_wdata | input | 16 | Write data |
| host_bmask | input | 2 | Byte-lane select, bit 0 low byte, bit 1 high byte |
| host_rdy | output | 1 | Controller idle and able to accept |
| host_rdata | output | 16 | Read data, unselected lanes zero |
| host_rvalid | output | 1 | One-cycle read-data strobe |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low-byte enable, active low |
| mem_ub_n | output | 1 | High-byte enable, active low |
| mem_dout | output | 16 | Data toward the memory pins |
| mem_dout_en | output | 1 | Tristate enable for mem_dout |
| mem_din | input | 16 | Data from the memory pins |

## Verification
Two events can land on the same clock: the completion of a read, when host_rvalid rises, and a new host request that reverses direction. The bench raises a write request in the very cycle it sees the read strobe. It then checks that host_rdy holds the request off until the controller is idle, and that the write waits out the full turnaround interval before the memory is enabled. A behavioural memory model marks any cycle in which the model and the controller drive the pins together, and the bench counts each such cycle as a failure. A final read-back confirms the write landed intact.

// File: rtl/asram_ctrl_pkg.sv
// Package: shared state type and the conversion from nanoseconds to wait cycles.
// Assumes that timing figures and the clock period are whole nanoseconds.
package asram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_READ_WAIT,
        ST_READ_CAPTURE,
        ST_WRITE_PULSE,
        ST_WRITE_RECOVER,
        ST_TURNAROUND
    } ctrl_state_t;

    // Rounds a time in ns up to whole clock cycles, never returning less than one.
    function automatic int ns_to_cycles(input int t_ns, input int period_ns);
        int c;
        c = (t_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_wait_timer.sv
// Wait timer: a load sets the remaining count, and done is high once it reaches zero.
// Assumes the owner loads COUNT-1 so that done rises in the COUNT-th cycle.
module asram_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Counts down to zero after each load, then holds at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_lane_ctrl.sv
// Byte-lane control: builds the active-low lane enables from the mask and zeroes
// the unselected lanes of read data. Assumes DATA_W = LANES * 8.
module asram_lane_ctrl #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0]   lane_mask,
    input  logic               mem_active,
    input  logic [LANES*8-1:0] raw_din,
    output logic [LANES-1:0]   lane_en_n,
    output logic [LANES*8-1:0] masked_din
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // A lane pin is low only while the chip is enabled and the lane is selected.
        assign lane_en_n[g] = ~(lane_mask[g] & mem_active);
        // Data from an unselected lane is forced to zero.
        assign masked_din[g*8 +: 8] = lane_mask[g] ? raw_din[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/asram_ctrl_fsm.sv
// Sequencer: accepts one request at a time, latches it, and steps through
// setup, strobe, capture/recover and turnaround states using the wait timer.
// Assumes the wait counts are at least 1 and fit in CNT_W bits.
module asram_ctrl_fsm
    import asram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LANES  = 2,
    parameter int CNT_W  = 4,
    parameter int WP_CYC = 1,
    parameter int RD_CYC = 2,
    parameter int HZ_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [LANES-1:0]  host_bmask,
    output logic              host_rdy,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic [LANES-1:0]  cur_mask,
    output logic              ce_act,
    output logic              oe_act,
    output logic              we_act,
    output logic              drv_act,
    output logic              rd_capture,
    output logic              rvalid
);
    ctrl_state_t      state_q, state_d;
    logic             op_we_q;
    logic             last_we_q, have_last_q;
    logic             accept, need_turn;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;

    assign accept    = host_req && (state_q == ST_IDLE);
    assign need_turn = have_last_q && (last_we_q != host_we);

    asram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    // Next-state and timer-load decision.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                if (need_turn) begin
                    state_d  = ST_TURNAROUND;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(HZ_CYC - 1);
                end else begin
                    state_d = ST_SETUP;
                end
            end
            ST_TURNAROUND: if (tmr_done) state_d = ST_SETUP;
            ST_SETUP: begin
                tmr_load = 1'b1;
                if (op_we_q) begin
                    state_d = ST_WRITE_PULSE;
                    tmr_val = CNT_W'(WP_CYC - 1);
                end else begin
                    state_d = ST_READ_WAIT;
                    tmr_val = CNT_W'(RD_CYC - 1);
                end
            end
            ST_WRITE_PULSE:   if (tmr_done) state_d = ST_WRITE_RECOVER;
            ST_WRITE_RECOVER: state_d = ST_IDLE;
            ST_READ_WAIT:     if (tmr_done) state_d = ST_READ_CAPTURE;
            ST_READ_CAPTURE:  state_d = ST_IDLE;
            default:          state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latches the accepted request and remembers the direction of the last transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr    <= '0;
            cur_wdata   <= '0;
            cur_mask    <= '0;
            op_we_q     <= 1'b0;
            last_we_q   <= 1'b0;
            have_last_q <= 1'b0;
        end else if (accept) begin
            cur_addr    <= host_addr;
            cur_wdata   <= host_wdata;
            cur_mask    <= host_bmask;
            op_we_q     <= host_we;
            last_we_q   <= host_we;
            have_last_q <= 1'b1;
        end
    end

    assign host_rdy   = (state_q == ST_IDLE);
    assign ce_act     = (state_q == ST_SETUP) || (state_q == ST_READ_WAIT) ||
                        (state_q == ST_WRITE_PULSE) || (state_q == ST_WRITE_RECOVER);
    assign oe_act     = !op_we_q && ((state_q == ST_SETUP) || (state_q == ST_READ_WAIT));
    assign we_act     = (state_q == ST_WRITE_PULSE);
    assign drv_act    = (state_q == ST_WRITE_PULSE) || (state_q == ST_WRITE_RECOVER);
    assign rd_capture = (state_q == ST_READ_WAIT) && tmr_done;
    assign rvalid     = (state_q == ST_READ_CAPTURE);

    // Checker state: length of the current write strobe.
    logic [CNT_W:0] we_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)      we_run_q <= '0;
        else if (we_act) we_run_q <= we_run_q + 1'b1;
        else             we_run_q <= '0;
    end

    assert_write_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_act) |-> (we_run_q == (CNT_W+1)'(WP_CYC)));

    assert_read_before_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_capture |-> (oe_act && ce_act && !we_act));

    assert_turn_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && need_turn) |=> !ce_act);
endmodule

// File: rtl/asram_bus_ctrl.sv
// Top: bus controller for a 64K x 16 asynchronous SRAM. Converts the ns timing
// parameters into wait counts, wires sequencer and lane logic to the pins, and
// registers the read data. Assumes the memory data pins are split externally
// into mem_dout/mem_dout_en (outbound) and mem_din (inbound).
module asram_bus_ctrl
    import asram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_WP_NS       = 8,
    parameter int T_DW_NS       = 6,
    parameter int T_AA_NS       = 12,
    parameter int T_RC_NS       = 12,
    parameter int T_HZ_NS       = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [1:0]        host_bmask,
    output logic              host_rdy,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);
    localparam int LANES   = DATA_W / 8;
    localparam int WP_CYC  = ns_to_cycles(imax(T_WP_NS, T_DW_NS), CLK_PERIOD_NS);
    localparam int RD_CYC  = ns_to_cycles(imax(T_AA_NS, T_RC_NS), CLK_PERIOD_NS);
    localparam int HZ_CYC  = ns_to_cycles(T_HZ_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC = imax(imax(WP_CYC, RD_CYC), HZ_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic              ce_act, oe_act, we_act, drv_act, rd_capture;
    logic [LANES-1:0]  cur_mask, lane_en_n;
    logic [DATA_W-1:0] cur_wdata, masked_din;

    asram_ctrl_fsm #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .LANES (LANES), .CNT_W (CNT_W),
        .WP_CYC (WP_CYC), .RD_CYC (RD_CYC), .HZ_CYC (HZ_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_bmask (host_bmask[LANES-1:0]),
        .host_rdy   (host_rdy),
        .cur_addr   (mem_addr),
        .cur_wdata  (cur_wdata),
        .cur_mask   (cur_mask),
        .ce_act     (ce_act),
        .oe_act     (oe_act),
        .we_act     (we_act),
        .drv_act    (drv_act),
        .rd_capture (rd_capture),
        .rvalid     (host_rvalid)
    );

    asram_lane_ctrl #(.LANES(LANES)) u_lanes (
        .lane_mask  (cur_mask),
        .mem_active (ce_act),
        .raw_din    (mem_din),
        .lane_en_n  (lane_en_n),
        .masked_din (masked_din)
    );

    // Registers the lane-masked read word on the last wait cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          host_rdata <= '0;
        else if (rd_capture) host_rdata <= masked_din;
    end

    assign mem_ce_n    = ~ce_act;
    assign mem_oe_n    = ~oe_act;
    assign mem_we_n    = ~we_act;
    assign mem_lb_n    = lane_en_n[0];
    assign mem_ub_n    = lane_en_n[LANES-1];
    assign mem_dout    = cur_wdata;
    assign mem_dout_en = drv_act;

    assert_idle_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdy |-> mem_ce_n);

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_rdy) |=> !host_rdy);

    assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> mem_oe_n);

    assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    assert_write_edge_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dout_en && $stable(mem_dout) && $stable(mem_addr)));

    assert_rvalid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    assert_lanes_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_lb_n && mem_ub_n));
endmodule

// File: tb/asram_bus_ctrl_tb.sv
// Directed bench with a behavioural byte-masked memory model and a bus contention monitor.
module asram_bus_ctrl_tb_top;
    localparam int PER   = 8;
    localparam int WP    = ((8 > 6 ? 8 : 6) + PER - 1) / PER;
    localparam int RD    = (12 + PER - 1) / PER;
    localparam int HZ    = (6 + PER - 1) / PER;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [15:0] host_addr = '0, host_wdata = '0;
    logic [1:0]  host_bmask = '0;
    logic        host_rdy, host_rvalid;
    logic [15:0] host_rdata;
    logic [15:0] mem_addr, mem_dout, mem_din;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dout_en;

    int checks = 0, fails = 0;
    logic model_on = 1'b0;
    logic [15:0] model_mem [256];

    always #(PER/2) clk = ~clk;

    asram_bus_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_bmask(host_bmask),
        .host_rdy(host_rdy), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
    );

    // Memory model: drives only the enabled lanes during a read, and garbage elsewhere.
    logic model_drive;
    assign model_drive = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_din = model_drive ?
        {(!mem_ub_n ? model_mem[mem_addr[7:0]][15:8] : 8'hC3),
         (!mem_lb_n ? model_mem[mem_addr[7:0]][7:0]  : 8'h3C)} : 16'hF00F;

    // Memory model: stores the enabled lanes on the rising edge of the write strobe.
    always @(posedge mem_we_n) begin
        if (model_on && !mem_ce_n) begin
            if (!mem_lb_n) model_mem[mem_addr[7:0]][7:0]  <= mem_dout[7:0];
            if (!mem_ub_n) model_mem[mem_addr[7:0]][15:8] <= mem_dout[15:8];
        end
    end

    // Contention monitor (R4): the controller and the memory must never drive together.
    always @(negedge clk) begin
        if (model_on && mem_dout_en && model_drive) begin
            fails++;
            $display("FAIL R4 contention: dout_en=%0d oe_n=%0d expected oe_n=1", mem_dout_en, mem_oe_n);
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Runs one transfer, returning ce-high gap, strobe counts, rvalid latency and the read data.
    task automatic do_op(input logic we, input logic [15:0] a, input logic [15:0] d,
                         input logic [1:0] m, output int gap, output int we_low,
                         output int drv, output int oe_low, output int rv_cnt,
                         output int rv_at, output logic [15:0] rdat);
        int n;
        gap = 0; we_low = 0; drv = 0; oe_low = 0; rv_cnt = 0; rv_at = 0; rdat = '0;
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d; host_bmask = m;
        @(negedge clk);
        host_req = 1'b0;
        chk(host_rdy == 1'b0, "R2 rdy low after accept", host_rdy, 0);
        n = 1;
        while (!host_rdy && n < 50) begin
            if (mem_ce_n && oe_low == 0 && we_low == 0 && drv == 0) gap++;
            if (!mem_we_n) we_low++;
            if (mem_dout_en) drv++;
            if (!mem_oe_n) oe_low++;
            if (host_rvalid) begin rv_cnt++; rv_at = n; rdat = host_rdata; end
            @(negedge clk);
            n++;
        end
        chk(host_rvalid == 1'b0, "R5 rvalid low in idle", host_rvalid, 0);
        chk(mem_ce_n == 1'b1, "R2 ce_n high when ready", mem_ce_n, 1);
    endtask

    task automatic t_reset;
        chk(host_rdy == 1'b1, "R1 rdy", host_rdy, 1);
        chk(host_rvalid == 1'b0, "R1 rvalid", host_rvalid, 0);
        chk({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'b11111, "R1 strobes",
            {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'b11111);
        chk(mem_dout_en == 1'b0, "R1 dout_en", mem_dout_en, 0);
    endtask

    task automatic t_write_read;
        int g, wl, dr, ol, rc, ra; logic [15:0] rd;
        do_op(1'b1, 16'h0010, 16'h1234, 2'b11, g, wl, dr, ol, rc, ra, rd);
        chk(g == 0, "R8 first op no turnaround", g, 0);
        chk(wl == WP, "R3 write strobe width", wl, WP);
        chk(dr == WP + 1, "R3 drive window", dr, WP + 1);
        chk(ol == 0 && rc == 0, "R3 no read strobes in write", ol + rc, 0);
        chk(model_mem[8'h10] == 16'h1234, "R3 word stored", model_mem[8'h10], 16'h1234);
        do_op(1'b0, 16'h0010, 16'h0000, 2'b11, g, wl, dr, ol, rc, ra, rd);
        chk(g == HZ, "R8 write->read turnaround", g, HZ);
        chk(ol == 1 + RD, "R5 oe_n low cycles", ol, 1 + RD);
        chk(rc == 1, "R5 single rvalid", rc, 1);
        chk(ra == HZ + 2 + RD, "R5 rvalid latency", ra, HZ + 2 + RD);
        chk(rd == 16'h1234, "R5 read data", rd, 16'h1234);
        do_op(1'b0, 16'h0010, 16'h0000, 2'b11, g, wl, dr, ol, rc, ra, rd);
        chk(g == 0, "R8 read->read no gap", g, 0);
        chk(ra == 2 + RD, "R5 rvalid latency no turn", ra, 2 + RD);
    endtask

    task automatic t_partial;
        int g, wl, dr, ol, rc, ra; logic [15:0] rd;
        do_op(1'b1, 16'h0021, 16'hA1B2, 2'b11, g, wl, dr, ol, rc, ra, rd);
        chk(g == HZ, "R8 read->write turnaround", g, HZ);
        do_op(1'b1, 16'h0021, 16'hFFCD, 2'b01, g, wl, dr, ol, rc, ra, rd);
        chk(g == 0, "R8 write->write no gap", g, 0);
        chk(model_mem[8'h21] == 16'hA1CD, "R6 low-lane write keeps high byte", model_mem[8'h21], 16'hA1CD);
        do_op(1'b1, 16'h0021, 16'h77EE, 2'b10, g, wl, dr, ol, rc, ra, rd);
        chk(model_mem[8'h21] == 16'h77CD, "R6 high-lane write keeps low byte", model_mem[8'h21], 16'h77CD);
        do_op(1'b0, 16'h0021, 16'h0000, 2'b11, g, wl, dr, ol, rc, ra, rd);
        chk(rd == 16'h77CD, "R6 merged word read", rd, 16'h77CD);
    endtask

    task automatic t_read_mask;
        int g, wl, dr, ol, rc, ra; logic [15:0] rd;
        do_op(1'b0, 16'h0021, 16'h0000, 2'b01, g, wl, dr, ol, rc, ra, rd);
        chk(rd == 16'h00CD, "R7 low-lane read zeroes high", rd, 16'h00CD);
        do_op(1'b0, 16'h0021, 16'h0000, 2'b10, g, wl, dr, ol, rc, ra, rd);
        chk(rd == 16'h7700, "R7 high-lane read zeroes low", rd, 16'h7700);
    endtask

    // A reversing write request raised in the same cycle as the read strobe.
    task automatic t_overlap;
        int n, gap; logic [15:0] rd;
        int g, wl, dr, ol, rc, ra;
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = 16'h0021; host_bmask = 2'b11;
        @(negedge clk);
        host_req = 1'b0;
        n = 0;
        while (!host_rvalid && n < 50) begin @(negedge clk); n++; end
        chk(host_rdata == 16'h77CD, "R5 overlap read data", host_rdata, 16'h77CD);
        host_req = 1'b1; host_we = 1'b1; host_addr = 16'h0033; host_wdata = 16'h5A5A; host_bmask = 2'b11;
        chk(host_rdy == 1'b0, "R2 held off during rvalid", host_rdy, 0);
        @(negedge clk);
        chk(host_rdy == 1'b1, "R2 ready after read", host_rdy, 1);
        @(negedge clk);
        host_req = 1'b0;
        gap = 0;
        while (mem_ce_n && gap < 50) begin gap++; @(negedge clk); end
        chk(gap == HZ, "R8 overlap turnaround", gap, HZ);
        n = 0;
        while (!host_rdy && n < 50) begin @(negedge clk); n++; end
        do_op(1'b0, 16'h0033, 16'h0000, 2'b11, g, wl, dr, ol, rc, ra, rd);
        chk(rd == 16'h5A5A, "R3 overlap write landed", rd, 16'h5A5A);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model_mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_partial();
        t_read_mask();
        t_overlap();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule